// File: doc/BRIEF.md
# Pulsed Input Impedance Detection Sequencer

This block schedules impedance measurements on a power input pin that currently has no supply on it. A programmable test current source is switched onto the pin in timed pulses. At the end of each pulse the sequencer latches an 8-bit converter sample and compares it with a software-set tag level. A low reading shows that the pin impedance is lower than intended, which points to moisture or a short. The first pulse waits for a wake-up delay. Later pulses repeat at a programmed period, or only one pulse runs.

Both the pulse width and the repetition period come from 4-bit codes. Each code selects a fixed, nonlinear time value. One width code holds the source on permanently, and one period code selects a single pulse. All time is counted in ticks of a 1 µs strobe. A new test is allowed only while detection is requested, the enable pin is low and the pin voltage is below the undervoltage level. If the pin is powered or the block is disabled, the sequencer returns to idle on the next edge and the source turns off. A one-cycle start pulse marks each new pulse, so the interrupt logic can release what it holds.

Top module: `impedance_det_seq`

## Requirements
- R1: After reset, `src_on`, `timer_start`, `timer_out`, `below_tag` and `result` are all zero.
- R2: The first pulse (`src_on` rising) begins exactly WAKE_US ticks after the first clock edge at which `det_en`=1, `en_n`=0 and `vin_present`=0 all hold.
- R3: For width code c (0..14), `src_on` stays high for exactly this many ticks: 200, 400, 1000, 2000, 4000, 10000, 20000, 40000, 100000, 200000, 400000, 1000000, 2000000, 4000000, 10000000 (listed for c = 0 to 14).
- R4: Width code 15 keeps `src_on` high with no end. Each `adc_valid` strobe loads `adc_data` into `result` on the next edge, and `timer_out` never rises in this mode.
- R5: Period code 0 produces exactly one pulse. For period code p (1..15), the start-to-start spacing is this many ticks: 10000, 20000, 50000, 100000, 200000, 500000, 1000000, 2000000, 3000000, 6000000, 12000000, 30000000, 60000000, 120000000, 300000000 (in units of 1 µs, listed for p = 1 to 15). When the period is not longer than the width, the next pulse starts one tick after the previous one ends.
- R6: On the edge where a pulse ends, `timer_out` is set to 1 and `result` takes the value `adc_data` has in that cycle.
- R7: Whenever `result` is loaded, `below_tag` is set to 1 if the sample is strictly less than `tag` (unsigned). Otherwise it is set to 0, and that includes the equal case.
- R8: `timer_start` is high for exactly one cycle at the start of every pulse, in the same cycle that `src_on` first reads high.
- R9: If `vin_present` or `en_n` goes high, `src_on` is low one cycle later and the sequencer is idle. A later restart waits the full wake-up delay again.
- R10: Clearing `det_en` turns `src_on` off one cycle later and returns the sequencer to idle.
- R11: `timer_out` is cleared at the start of each pulse. `result`, `timer_out` and `below_tag` otherwise hold their values, including while the sequencer is idle.
- R12: Timers advance only on cycles where `tick_us` is high. A slower tick stretches every interval in proportion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe every 1 µs |
| det_en | input | 1 | Detection request from software |
| en_n | input | 1 | Device enable pin, active low |
| vin_present | input | 1 | High when the input pin is above the undervoltage level |
| width_code | input | 4 | Pulse width selection code |
| period_code | input | 4 | Repetition period code; 0 selects a single pulse |
| tag | input | 8 | Threshold for the below-tag judgement |
| adc_data | input | 8 | Converter sample of the pin voltage |
| adc_valid | input | 1 | New-sample strobe, used in always-on mode |
| src_on | output | 1 | Test current source enable |
| result | output | 8 | Latched sample |
| timer_out | output | 1 | Pulse timer expired; result valid |
| below_tag | output | 1 | Latched sample was below the tag |
| timer_start | output | 1 | One-cycle pulse at each pulse start |

## Verification
Several properties are checked on every cycle by the assertions. An abort or a cleared request always leaves the source off on the next cycle. A start pulse lasts one cycle and always coincides with the source being on. Each freshly loaded result agrees with the tag flag. The timeout status never rises in always-on mode, and the counter holds still between ticks. Only the bench scenarios can show the absolute timing. That covers the exact wake-up delay, the width and period tables, single-shot against repeating behaviour, the restart after an abort and the proportional stretch under a slower tick, because these depend on counting long intervals against the code tables.

// File: rtl/det_pkg.sv
// Shared types and code tables for the impedance detection sequencer.
// Assumes timing values are expressed in 1 us ticks and fit in 32 bits.
package det_pkg;

    typedef enum logic [2:0] {
        DS_IDLE,
        DS_WAKE,
        DS_PULSE,
        DS_GAP,
        DS_DONE
    } det_state_e;

    localparam logic [3:0] CODE_STEADY  = 4'hF;
    localparam logic [3:0] CODE_ONESHOT = 4'h0;

    // Source-on width in ticks for a width code (code 15 is handled as always-on).
    function automatic logic [31:0] pulse_ticks(input logic [3:0] code);
        case (code)
            4'd0:    pulse_ticks = 32'd200;
            4'd1:    pulse_ticks = 32'd400;
            4'd2:    pulse_ticks = 32'd1000;
            4'd3:    pulse_ticks = 32'd2000;
            4'd4:    pulse_ticks = 32'd4000;
            4'd5:    pulse_ticks = 32'd10000;
            4'd6:    pulse_ticks = 32'd20000;
            4'd7:    pulse_ticks = 32'd40000;
            4'd8:    pulse_ticks = 32'd100000;
            4'd9:    pulse_ticks = 32'd200000;
            4'd10:   pulse_ticks = 32'd400000;
            4'd11:   pulse_ticks = 32'd1000000;
            4'd12:   pulse_ticks = 32'd2000000;
            4'd13:   pulse_ticks = 32'd4000000;
            4'd14:   pulse_ticks = 32'd10000000;
            default: pulse_ticks = 32'hFFFF_FFFF;
        endcase
    endfunction

    // Start-to-start spacing in ticks for a period code (code 0 is single-shot).
    function automatic logic [31:0] period_ticks(input logic [3:0] code);
        case (code)
            4'd1:    period_ticks = 32'd10000;
            4'd2:    period_ticks = 32'd20000;
            4'd3:    period_ticks = 32'd50000;
            4'd4:    period_ticks = 32'd100000;
            4'd5:    period_ticks = 32'd200000;
            4'd6:    period_ticks = 32'd500000;
            4'd7:    period_ticks = 32'd1000000;
            4'd8:    period_ticks = 32'd2000000;
            4'd9:    period_ticks = 32'd3000000;
            4'd10:   period_ticks = 32'd6000000;
            4'd11:   period_ticks = 32'd12000000;
            4'd12:   period_ticks = 32'd30000000;
            4'd13:   period_ticks = 32'd60000000;
            4'd14:   period_ticks = 32'd120000000;
            4'd15:   period_ticks = 32'd300000000;
            default: period_ticks = 32'd1;
        endcase
    endfunction

endpackage

// File: rtl/det_timebase.sv
// Tick counter shared by the wake, pulse and gap phases.
// Assumes clear has priority and the count only moves on a tick.
module det_timebase #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);

    // Count elapsed ticks since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clear)  cnt <= '0;
        else if (tick)   cnt <= cnt + 1'b1;
    end

    assert_hold_without_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !tick) |=> $stable(cnt))
        else $error("count moved without a tick");

endmodule

// File: rtl/det_seq.sv
// Phase sequencer: wake delay, pulse, gap, single-shot done.
// Assumes run_ok already combines request, enable pin and undervoltage state.
module det_seq
    import det_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int WAKE_US = 1500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_ok,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [3:0]       width_code,
    input  logic [3:0]       period_code,
    input  logic             adc_valid,
    output logic             cnt_clear,
    output logic             start_now,
    output logic             expire_now,
    output logic             live_take,
    output logic             src_on,
    output logic             start_pulse
);

    localparam logic [CNT_W-1:0] WAKE_LIM = CNT_W'(WAKE_US - 1);

    det_state_e       st, nxt;
    logic [CNT_W-1:0] width_lim, period_lim;
    logic             steady;

    // Decode the limits for the current codes.
    always_comb begin
        width_lim  = CNT_W'(pulse_ticks(width_code) - 32'd1);
        period_lim = CNT_W'(period_ticks(period_code) - 32'd1);
        steady     = (width_code == CODE_STEADY);
    end

    // Next-phase decision, with start and expiry events.
    always_comb begin
        nxt        = st;
        start_now  = 1'b0;
        expire_now = 1'b0;
        if (!run_ok) begin
            nxt = DS_IDLE;
        end else begin
            case (st)
                DS_IDLE:  nxt = DS_WAKE;
                DS_WAKE:  if (tick && cnt == WAKE_LIM) begin
                              start_now = 1'b1;
                              nxt       = DS_PULSE;
                          end
                DS_PULSE: if (!steady && tick && cnt >= width_lim) begin
                              expire_now = 1'b1;
                              nxt = (period_code == CODE_ONESHOT) ? DS_DONE : DS_GAP;
                          end
                DS_GAP:   if (tick && cnt >= period_lim) begin
                              start_now = 1'b1;
                              nxt       = DS_PULSE;
                          end
                default:  nxt = DS_DONE;
            endcase
        end
        cnt_clear = !run_ok || (st == DS_IDLE) || (st == DS_DONE) || start_now;
        live_take = run_ok && (st == DS_PULSE) && steady && adc_valid;
    end

    // Phase register and registered source and start outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= DS_IDLE;
            src_on      <= 1'b0;
            start_pulse <= 1'b0;
        end else begin
            st          <= nxt;
            src_on      <= (nxt == DS_PULSE);
            start_pulse <= start_now;
        end
    end

    assert_abort_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_ok |=> !src_on)
        else $error("source on after abort");

    assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse)
        else $error("start pulse longer than one cycle");

    assert_start_with_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> src_on)
        else $error("start pulse without source");

endmodule

// File: rtl/det_capture.sv
// Result latch with timeout status and below-tag judgement.
// Assumes start, expiry and live-capture events never coincide.
module det_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_now,
    input  logic              expire_now,
    input  logic              live_take,
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] tag,
    output logic [DATA_W-1:0] result,
    output logic              timer_out,
    output logic              below_tag
);

    // Load the sample and its tag comparison on any capture event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            below_tag <= 1'b0;
        end else if (expire_now || live_take) begin
            result    <= sample;
            below_tag <= (sample < tag);
        end
    end

    // Timeout status: cleared at pulse start, set at pulse expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)          timer_out <= 1'b0;
        else if (start_now)  timer_out <= 1'b0;
        else if (expire_now) timer_out <= 1'b1;
    end

    assert_tag_compare_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> (below_tag == (result < $past(tag))))
        else $error("tag flag disagrees with result");

endmodule

// File: rtl/impedance_det_seq.sv
// Top of the pulsed impedance detection sequencer.
// Assumes tick_us is a single-cycle strobe and inputs are synchronous to clk.
module impedance_det_seq
    import det_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int DATA_W  = 8,
    parameter int WAKE_US = 1500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_us,
    input  logic              det_en,
    input  logic              en_n,
    input  logic              vin_present,
    input  logic [3:0]        width_code,
    input  logic [3:0]        period_code,
    input  logic [DATA_W-1:0] tag,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              adc_valid,
    output logic              src_on,
    output logic [DATA_W-1:0] result,
    output logic              timer_out,
    output logic              below_tag,
    output logic              timer_start
);

    logic             run_ok;
    logic             cnt_clear, start_now, expire_now, live_take;
    logic [CNT_W-1:0] cnt;

    // Detection is allowed only when requested, enabled and unpowered.
    assign run_ok = det_en && !en_n && !vin_present;

    det_timebase #(.CNT_W(CNT_W)) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .tick  (tick_us),
        .cnt   (cnt)
    );

    det_seq #(.CNT_W(CNT_W), .WAKE_US(WAKE_US)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_ok      (run_ok),
        .tick        (tick_us),
        .cnt         (cnt),
        .width_code  (width_code),
        .period_code (period_code),
        .adc_valid   (adc_valid),
        .cnt_clear   (cnt_clear),
        .start_now   (start_now),
        .expire_now  (expire_now),
        .live_take   (live_take),
        .src_on      (src_on),
        .start_pulse (timer_start)
    );

    det_capture #(.DATA_W(DATA_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_now  (start_now),
        .expire_now (expire_now),
        .live_take  (live_take),
        .sample     (adc_data),
        .tag        (tag),
        .result     (result),
        .timer_out  (timer_out),
        .below_tag  (below_tag)
    );

    assert_steady_no_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timer_out) |-> ($past(width_code) != CODE_STEADY))
        else $error("timeout set in always-on mode");

    assert_request_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |=> !src_on)
        else $error("source on without request");

endmodule

// File: tb/sim_impedance_det_seq.sv
`timescale 1ns/1ps
module sim_impedance_det_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us = 1'b1;
    logic       det_en = 1'b0, en_n = 1'b0, vin_present = 1'b0;
    logic [3:0] width_code = 4'd0, period_code = 4'd0;
    logic [7:0] tag = 8'd0, adc_data = 8'd0;
    logic       adc_valid = 1'b0;
    logic       src_on, timer_out, below_tag, timer_start;
    logic [7:0] result;

    int  cyc = 0;
    int  vectors = 0;
    int  fails = 0;
    logic half_rate = 1'b0;

    localparam int WAKE = 1500;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) tick_us <= half_rate ? ~tick_us : 1'b1;

    impedance_det_seq u0 (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .det_en(det_en), .en_n(en_n),
        .vin_present(vin_present), .width_code(width_code), .period_code(period_code),
        .tag(tag), .adc_data(adc_data), .adc_valid(adc_valid), .src_on(src_on),
        .result(result), .timer_out(timer_out), .below_tag(below_tag),
        .timer_start(timer_start)
    );

    function automatic int width_of(int code);
        case (code)
            0: return 200;  1: return 400;  2: return 1000;
            3: return 2000; 4: return 4000; default: return 0;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    task automatic wait_rise(input int limit, output int rc);
        rc = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (src_on) begin rc = cyc; break; end
        end
    endtask

    task automatic count_high(output int w);
        w = 1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!src_on) break;
            w++;
        end
    endtask

    task automatic idle_request();
        @(negedge clk);
        det_en = 1'b0;
        @(negedge clk);
        check("R10 source off after request cleared", int'(src_on), 0);
    endtask

    always @(posedge clk) begin
        if (cyc == 190000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int c0, rc, rc2, rc3, w;
        logic [7:0] v;
        repeat (4) @(negedge clk);
        check("R1 src_on at reset", int'(src_on), 0);
        check("R1 timer_start at reset", int'(timer_start), 0);
        check("R1 timer_out at reset", int'(timer_out), 0);
        check("R1 below_tag at reset", int'(below_tag), 0);
        check("R1 result at reset", int'(result), 0);
        rst_n = 1'b1;

        // Single-shot sweep over width codes 0..4.
        for (int code = 0; code < 5; code++) begin
            @(negedge clk);
            width_code = 4'(code); period_code = 4'd0;
            v = 8'(code * 61 + 3);
            adc_data = v;
            tag = (code % 2 == 0) ? v + 8'd1 : v;
            det_en = 1'b1; c0 = cyc;
            wait_rise(WAKE + 10, rc);
            check("R2 wake delay", rc - c0, WAKE + 1);
            check("R8 start pulse at rise", int'(timer_start), 1);
            check("R11 timeout cleared at start", int'(timer_out), 0);
            count_high(w);
            check("R3 pulse width", w, width_of(code));
            check("R6 timeout set", int'(timer_out), 1);
            check("R6 result captured", int'(result), int'(v));
            check("R7 below tag", int'(below_tag), (code % 2 == 0) ? 1 : 0);
            wait_rise(3000, rc2);
            check("R5 single shot no second pulse", rc2, -1);
            idle_request();
            check("R11 result held while idle", int'(result), int'(v));
        end

        // Periodic pulses: width codes 0 and 3 with period code 1.
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            width_code = (k == 0) ? 4'd0 : 4'd3; period_code = 4'd1;
            adc_data = 8'd0; tag = 8'd0;
            det_en = 1'b1;
            wait_rise(WAKE + 10, rc);
            count_high(w);
            check("R7 equal zero not below", int'(below_tag), 0);
            adc_data = 8'd200; tag = 8'd255;
            wait_rise(12000, rc2);
            check("R5 period spacing", rc2 - rc, 10000);
            check("R8 start pulse repeats", int'(timer_start), 1);
            check("R11 timeout cleared at repeat", int'(timer_out), 0);
            count_high(w);
            check("R6 recapture", int'(result), 200);
            check("R7 below after recapture", int'(below_tag), 1);
            wait_rise(12000, rc3);
            check("R5 period spacing second", rc3 - rc2, 10000);
            idle_request();
        end

        // Always-on mode.
        @(negedge clk);
        width_code = 4'hF; period_code = 4'd0; tag = 8'd100; adc_data = 8'd0;
        det_en = 1'b1;
        wait_rise(WAKE + 10, rc);
        repeat (500) @(negedge clk);
        check("R4 source still on", int'(src_on), 1);
        adc_data = 8'd42; adc_valid = 1'b1;
        @(negedge clk); adc_valid = 1'b0;
        check("R4 live result", int'(result), 42);
        check("R7 live below", int'(below_tag), 1);
        adc_data = 8'd255; adc_valid = 1'b1;
        @(negedge clk); adc_valid = 1'b0;
        check("R4 live result max", int'(result), 255);
        check("R7 live not below", int'(below_tag), 0);
        repeat (300) @(negedge clk);
        check("R4 no timeout in always-on", int'(timer_out), 0);
        idle_request();

        // Abort by input voltage mid-pulse, then full restart.
        @(negedge clk);
        width_code = 4'd2; period_code = 4'd0; det_en = 1'b1;
        wait_rise(WAKE + 10, rc);
        repeat (100) @(negedge clk);
        vin_present = 1'b1;
        @(negedge clk);
        check("R9 abort on input voltage", int'(src_on), 0);
        check("R9 no timeout on abort", int'(timer_out), 0);
        repeat (20) @(negedge clk);
        vin_present = 1'b0; c0 = cyc;
        wait_rise(WAKE + 10, rc);
        check("R9 restart waits full delay", rc - c0, WAKE + 1);
        // Abort by enable pin.
        en_n = 1'b1;
        @(negedge clk);
        check("R9 abort on enable pin", int'(src_on), 0);
        en_n = 1'b0;
        idle_request();

        // Request cleared mid-pulse.
        @(negedge clk);
        width_code = 4'd4; det_en = 1'b1;
        wait_rise(WAKE + 10, rc);
        repeat (50) @(negedge clk);
        det_en = 1'b0;
        @(negedge clk);
        check("R10 off mid-pulse", int'(src_on), 0);
        wait_rise(2000, rc2);
        check("R10 stays idle", rc2, -1);

        // Half-rate tick stretches the pulse.
        @(negedge clk);
        half_rate = 1'b1; width_code = 4'd0; det_en = 1'b1;
        wait_rise(2 * WAKE + 20, rc);
        count_high(w);
        check("R12 stretched width in range", int'(w >= 399 && w <= 400), 1);
        idle_request();
        half_rate = 1'b0;

        summary();
        $finish;
    end

endmodule